// File: doc/BRIEF.md
# Configurable Output Logic Cell

This block is one logic cell of a programmable-logic fabric. It receives the sum-of-products term computed by the array in front of it, and a set of static configuration bits decides how that term reaches the pin. The term can pass straight through as combinational logic. It can be held in a transparent latch. It can also be stored in a flip-flop that loads the term (D behaviour) or toggles on it (T behaviour). A polarity bit inverts the value driven to the pad. A select field picks one of four clock lines to serve as the edge or latch gate.

The storage element has two shared asynchronous controls, clear and set, and a power-on clear. A synchronous preload port forces a chosen value into the flip-flop for test. The cell sends its stored value back to the array on a feedback line that is taken before the polarity inversion. When the cell is buried, its output driver is released, so the pin acts as an input. In that case the cell captures the pin instead of the sum term, as a D register, a latch, or a direct path, which lets an asynchronous signal be synchronised.

Top module: `plmc_cell`

## Requirements
- R1: With cfg_mode = 2'b00 (or 2'b11), the cell is combinational: fb_out equals the selected source, and pad_out equals that source XOR cfg_inv, with no clock needed.
- R2: With cfg_mode = 2'b01, the cell is a latch. It is transparent while the selected clock line is high and holds its value while that line is low.
- R3: With cfg_mode = 2'b10 and cfg_tflop = 0, the cell loads the source value on each rising edge of the selected clock.
- R4: With cfg_mode = 2'b10 and cfg_tflop = 1, the stored bit inverts on a rising edge when the source is 1 and is unchanged when the source is 0.
- R5: cfg_inv inverts pad_out only. fb_out always carries the stored value or the pass-through value before inversion.
- R6: cfg_csel = k makes clk_bank[k] the only clock line that acts on the cell. Edges on the other lines have no effect.
- R7: async_set forces the stored bit to 1 and async_clr forces it to 0 at once, with no clock edge. When both are high, the bit is 0.
- R8: While por_n is low, the stored bit is 0. This is the defined state after power-up.
- R9: In register mode, preload_en = 1 at a rising edge loads preload_val and overrides both D and T behaviour. It ranks below async_clr and async_set.
- R10: pad_oe follows oe_term when the cell is not buried. While pad_oe is 0, pad_out is 0. fb_out does not depend on oe_term.
- R11: With cfg_buried = 1, pad_oe is 0 and the source is pin_in instead of sum_in. Register mode then captures pin_in as a D register whatever cfg_tflop is set to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bank | input | 4 | The four clock lines the cell can select from |
| por_n | input | 1 | Power-on clear, active low, asynchronous |
| async_clr | input | 1 | Shared asynchronous clear, active high |
| async_set | input | 1 | Shared asynchronous set, active high |
| sum_in | input | 1 | Sum-of-products term from the array |
| pin_in | input | 1 | Value present at the pin, used when the cell is buried |
| oe_term | input | 1 | Output-enable term |
| cfg_mode | input | 2 | 00/11 combinational, 01 latch, 10 register |
| cfg_tflop | input | 1 | Register type: 0 for D, 1 for T |
| cfg_inv | input | 1 | Output polarity: 1 inverts pad_out |
| cfg_csel | input | 2 | Index of the selected clock line |
| cfg_buried | input | 1 | Buried cell with a pin-input register |
| preload_en | input | 1 | Test preload strobe, sampled on the selected edge |
| preload_val | input | 1 | Value loaded by the preload |
| pad_out | output | 1 | Value driven to the pad |
| pad_oe | output | 1 | Pad driver enable; 0 means high impedance |
| fb_out | output | 1 | Feedback to the array, taken before inversion |

## Verification
A wrong stored bit reaches fb_out directly. For the flip-flop it appears right after the selected rising edge; for the latch it appears while the gate is open. With the driver enabled, the same error also reaches pad_out. A polarity or enable fault, by contrast, shows on pad_out alone while fb_out stays correct, so comparing the two ports in the same cycle tells the two kinds of fault apart. Errors in clock selection or in the asynchronous controls show on the very next pulse or level change: an edge on a clock that is not selected must leave fb_out unchanged, and a clear or set must move it with no edge at all.

// File: rtl/plmc_pkg.sv
package plmc_pkg;
  typedef enum logic [1:0] {
    MODE_COMB  = 2'b00,
    MODE_LATCH = 2'b01,
    MODE_REG   = 2'b10,
    MODE_ALT   = 2'b11
  } plmc_mode_e;

  // Next value of the register for D (load) or T (toggle on 1) behaviour.
  function automatic logic reg_next(input logic cur, input logic src, input logic toggle);
    return toggle ? (cur ^ src) : src;
  endfunction

  // Polarity stage applied only on the way to the pad.
  function automatic logic apply_pol(input logic v, input logic inv);
    return v ^ inv;
  endfunction
endpackage

// File: rtl/plmc_clk_pick.sv
module plmc_clk_pick #(
  parameter int N_CLK  = 4,
  parameter int CSEL_W = (N_CLK > 1) ? $clog2(N_CLK) : 1
) (
  input  logic [N_CLK-1:0]  clk_bank,
  input  logic [CSEL_W-1:0] sel,
  output logic              clk_g
);
  generate
    if (N_CLK == 1) begin : g_single
      logic unused_sel;
      assign unused_sel = ^sel;
      assign clk_g = clk_bank[0];
    end else begin : g_multi
      assign clk_g = clk_bank[sel];
    end
  endgenerate
endmodule

// File: rtl/plmc_store.sv
module plmc_store
  import plmc_pkg::*;
(
  input  logic       clk_g,
  input  logic       clr,
  input  logic       set,
  input  logic       d_src,
  input  plmc_mode_e mode,
  input  logic       tflop,
  input  logic       preload_en,
  input  logic       preload_val,
  output logic       st_q
);
  logic is_reg, is_latch;
  logic ff_q, lat_q;
  logic async_any;
  logic t_cond, d_cond, pl_cond;
  logic arm;

  assign is_reg    = (mode == MODE_REG);
  assign is_latch  = (mode == MODE_LATCH);
  assign async_any = clr | set;

  // Event wires brought out for the checks below.
  assign t_cond  = is_reg & ~preload_en & tflop;
  assign d_cond  = is_reg & ~preload_en & ~tflop;
  assign pl_cond = is_reg & preload_en;

  always_ff @(posedge clk_g or posedge clr or posedge set) begin
    if (clr)            ff_q <= 1'b0;
    else if (set)       ff_q <= 1'b1;
    else if (is_reg) begin
      if (preload_en)   ff_q <= preload_val;
      else              ff_q <= reg_next(ff_q, d_src, tflop);
    end
  end

  always_latch begin
    if (clr)                     lat_q = 1'b0;
    else if (set)                lat_q = 1'b1;
    else if (is_latch && clk_g)  lat_q = d_src;
  end

  always_comb begin
    unique case (mode)
      MODE_LATCH: st_q = lat_q;
      MODE_REG:   st_q = ff_q;
      default:    st_q = d_src;
    endcase
  end

  // Armed once a clean edge has passed with no asynchronous action since.
  always_ff @(posedge clk_g or posedge async_any) begin
    if (async_any) arm <= 1'b0;
    else           arm <= 1'b1;
  end

  // R7
  clear_wins_chk: assert property (@(posedge clk_g) disable iff (!clr) clr |-> (ff_q == 1'b0));
  // R3
  d_load_chk: assert property (@(posedge clk_g) disable iff (async_any)
    (arm && $past(d_cond)) |-> (ff_q == $past(d_src)));
  // R4
  t_toggle_chk: assert property (@(posedge clk_g) disable iff (async_any)
    (arm && $past(t_cond)) |-> (ff_q == ($past(ff_q) ^ $past(d_src))));
  // R9
  preload_chk: assert property (@(posedge clk_g) disable iff (async_any)
    (arm && $past(pl_cond)) |-> (ff_q == $past(preload_val)));
endmodule

// File: rtl/plmc_out.sv
module plmc_out
  import plmc_pkg::*;
(
  input  logic st_q,
  input  logic inv,
  input  logic oe_term,
  input  logic buried,
  output logic pad_out,
  output logic pad_oe,
  output logic fb_out
);
  assign fb_out  = st_q;
  assign pad_oe  = oe_term & ~buried;
  assign pad_out = pad_oe ? apply_pol(st_q, inv) : 1'b0;
endmodule

// File: rtl/plmc_cell.sv
module plmc_cell
  import plmc_pkg::*;
#(
  parameter int N_CLK  = 4,
  localparam int CSEL_W = (N_CLK > 1) ? $clog2(N_CLK) : 1
) (
  input  logic [N_CLK-1:0]  clk_bank,
  input  logic              por_n,
  input  logic              async_clr,
  input  logic              async_set,
  input  logic              sum_in,
  input  logic              pin_in,
  input  logic              oe_term,
  input  logic [1:0]        cfg_mode,
  input  logic              cfg_tflop,
  input  logic              cfg_inv,
  input  logic [CSEL_W-1:0] cfg_csel,
  input  logic              cfg_buried,
  input  logic              preload_en,
  input  logic              preload_val,
  output logic              pad_out,
  output logic              pad_oe,
  output logic              fb_out
);
  logic       clk_g;
  logic       clr_all;
  logic       d_src;
  logic       t_eff;
  logic       st_q;
  plmc_mode_e mode;

  assign clr_all = ~por_n | async_clr;
  assign d_src   = cfg_buried ? pin_in : sum_in;
  assign t_eff   = cfg_tflop & ~cfg_buried;
  assign mode    = plmc_mode_e'(cfg_mode);

  plmc_clk_pick #(.N_CLK(N_CLK), .CSEL_W(CSEL_W)) u_clk (
    .clk_bank (clk_bank),
    .sel      (cfg_csel),
    .clk_g    (clk_g)
  );

  plmc_store u_store (
    .clk_g       (clk_g),
    .clr         (clr_all),
    .set         (async_set),
    .d_src       (d_src),
    .mode        (mode),
    .tflop       (t_eff),
    .preload_en  (preload_en),
    .preload_val (preload_val),
    .st_q        (st_q)
  );

  plmc_out u_out (
    .st_q    (st_q),
    .inv     (cfg_inv),
    .oe_term (oe_term),
    .buried  (cfg_buried),
    .pad_out (pad_out),
    .pad_oe  (pad_oe),
    .fb_out  (fb_out)
  );

  // R5
  pol_split_chk: assert property (@(posedge clk_g) disable iff (!por_n)
    pad_oe |-> ((pad_out ^ fb_out) == cfg_inv));
  // R11
  buried_release_chk: assert property (@(posedge clk_g) disable iff (!por_n)
    cfg_buried |-> (pad_oe == 1'b0));
endmodule

// File: tb/sim_plmc_cell.sv
module sim_plmc_cell;
  logic       clk = 1'b0;
  logic [3:0] clk_bank = 4'b0000;
  logic       por_n = 1'b0, async_clr = 1'b0, async_set = 1'b0;
  logic       sum_in = 1'b0, pin_in = 1'b0, oe_term = 1'b1;
  logic [1:0] cfg_mode = 2'b10, cfg_csel = 2'b00;
  logic       cfg_tflop = 1'b0, cfg_inv = 1'b0, cfg_buried = 1'b0;
  logic       preload_en = 1'b0, preload_val = 1'b0;
  logic       pad_out, pad_oe, fb_out;
  int         checks = 0, errors = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  plmc_cell u0 (
    .clk_bank(clk_bank), .por_n(por_n), .async_clr(async_clr), .async_set(async_set),
    .sum_in(sum_in), .pin_in(pin_in), .oe_term(oe_term), .cfg_mode(cfg_mode),
    .cfg_tflop(cfg_tflop), .cfg_inv(cfg_inv), .cfg_csel(cfg_csel), .cfg_buried(cfg_buried),
    .preload_en(preload_en), .preload_val(preload_val),
    .pad_out(pad_out), .pad_oe(pad_oe), .fb_out(fb_out)
  );

  // {mode[1:0], tflop, inv, csel[1:0], sum, exp_pad, exp_fb}; walked in order
  localparam logic [8:0] VEC [10] = '{
    9'b000000111, 9'b000100101, 9'b000100010, 9'b100000111, 9'b100101010,
    9'b100010111, 9'b101011100, 9'b101011111, 9'b101111001, 9'b101000100
  };

  task automatic chk(input string rq, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", rq, act, exp);
    end
  endtask

  task automatic pulse(input int idx);
    #2 clk_bank[idx] = 1'b1;
    #4 clk_bank[idx] = 1'b0;
    #4;
  endtask

  initial begin
    #10;
    // R8: power-on state in register mode
    chk("R8 por fb", fb_out, 1'b0);
    chk("R8 por pad", pad_out, 1'b0);
    pulse(0);
    chk("R8 held in reset", fb_out, 1'b0);
    por_n = 1'b1; #4;

    // Table walk: R1 R3 R4 R5 R6
    for (int i = 0; i < 10; i++) begin
      {cfg_mode, cfg_tflop, cfg_inv, cfg_csel, sum_in} = VEC[i][8:2];
      #2;
      pulse(int'(VEC[i][4:3]));
      chk($sformatf("R1/R3/R4/R5 vec%0d pad", i), pad_out, VEC[i][1]);
      chk($sformatf("R1/R3/R4/R5 vec%0d fb", i), fb_out, VEC[i][0]);
    end

    // R6: unselected clocks ignored (state 0 after table)
    cfg_mode = 2'b10; cfg_tflop = 1'b0; cfg_inv = 1'b0; cfg_csel = 2'd1; sum_in = 1'b1; #2;
    pulse(0); pulse(2); pulse(3);
    chk("R6 other clocks ignored", fb_out, 1'b0);
    pulse(1);
    chk("R6 selected clock loads", fb_out, 1'b1);

    // R2: latch transparency and hold
    cfg_mode = 2'b01; cfg_csel = 2'd0; sum_in = 1'b1; #2;
    clk_bank[0] = 1'b1; #2;
    chk("R2 open passes 1", fb_out, 1'b1);
    sum_in = 1'b0; #2;
    chk("R2 open passes 0", fb_out, 1'b0);
    clk_bank[0] = 1'b0; #2;
    sum_in = 1'b1; #2;
    chk("R2 closed holds", fb_out, 1'b0);
    clk_bank[0] = 1'b1; #2;
    chk("R2 reopen", fb_out, 1'b1);
    clk_bank[0] = 1'b0; #2;

    // R7: asynchronous controls in register mode
    cfg_mode = 2'b10; sum_in = 1'b0; #2;
    pulse(0);
    async_set = 1'b1; #2;
    chk("R7 set no edge", fb_out, 1'b1);
    async_clr = 1'b1; #2;
    chk("R7 clear wins", fb_out, 1'b0);
    async_set = 1'b0; #2; async_clr = 1'b0; #2;
    chk("R7 stays clear", fb_out, 1'b0);
    cfg_mode = 2'b01; async_set = 1'b1; #2; async_set = 1'b0; #2;
    chk("R7 latch set", fb_out, 1'b1);

    // R8: power-on clear mid-run
    cfg_mode = 2'b10; sum_in = 1'b1; #2; pulse(0);
    por_n = 1'b0; #2;
    chk("R8 por clears", fb_out, 1'b0);
    por_n = 1'b1; #2;

    // R9: preload overrides D and T
    sum_in = 1'b0; preload_en = 1'b1; preload_val = 1'b1; #2; pulse(0);
    chk("R9 preload over D", fb_out, 1'b1);
    cfg_tflop = 1'b1; sum_in = 1'b1; preload_val = 1'b1; #2; pulse(0);
    chk("R9 preload over T", fb_out, 1'b1);
    preload_en = 1'b0; cfg_tflop = 1'b0; #2;

    // R10: output enable
    oe_term = 1'b0; cfg_inv = 1'b1; #2;
    chk("R10 oe low", pad_oe, 1'b0);
    chk("R10 pad zero", pad_out, 1'b0);
    chk("R10 fb kept", fb_out, 1'b1);
    oe_term = 1'b1; #2;
    chk("R10 oe high pad", pad_out, 1'b0);
    cfg_inv = 1'b0;

    // R11: buried cell captures the pin
    cfg_buried = 1'b1; cfg_tflop = 1'b1; sum_in = 1'b1; pin_in = 1'b1; #2; pulse(0);
    chk("R11 driver off", pad_oe, 1'b0);
    chk("R11 D capture 1", fb_out, 1'b1);
    pulse(0);
    chk("R11 no toggle", fb_out, 1'b1);
    pin_in = 1'b0; #2; pulse(0);
    chk("R11 D capture 0", fb_out, 1'b0);
    cfg_mode = 2'b00; pin_in = 1'b1; #2;
    chk("R11 comb pin", fb_out, 1'b1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule